// File: doc/BRIEF.md
# Glitch-free multi-source clock selector

This block picks one of several free-running source clocks and forwards it as a single functional clock, changing source without ever emitting a runt pulse. A source index arrives from a control register in the register-clock domain. The block hands the output over in two steps. First, the enable of the outgoing source is withdrawn on that source's own falling edge. Then, once that release has crossed into the incoming source's domain, the incoming source is enabled on its own falling edge.

A status word, synchronised back into the register-clock domain, holds one bit per source and shows which source actually drives the output. It reads all zeros from the cycle after a change is accepted until the new source is confirmed. Because the handover needs edges from both clocks, a switch toward a stopped clock stalls with the status at zero. The default build has five sources. Setting `N_SRC` to 2 gives the two-input form, which has a 1-bit select and a 2-bit status.

Top module: `gf_clk_sel`

## Requirements
- R1: When the status is non-zero, `clk_o` toggles with the same period as the source whose status bit is set.
- R2: The status is one-hot when settled. Bit i set, i.e. value 1<<i, means source i drives `clk_o`: 0x01, 0x02, 0x04, 0x08 and 0x10 for sources 0 to 4. In the 2-input build the values are 0x1 and 0x2.
- R3: A valid select that differs from the settled source is taken at a rising `reg_clk` edge. The status reads 0 from the next cycle until the new source is confirmed.
- R4: A select code of N_SRC or more (5, 6 or 7 in the default build) is ignored. The current source stays, and the status and `clk_o` are unchanged.
- R5: A synchronous active-low reset, sampled on `reg_clk`, selects source 0. After the first `reg_clk` edge in reset, the status reads 0x01.
- R6: A switch completes only when both the old and the new source clocks toggle. While the target clock is stopped, the status stays 0 and `clk_o` stays low.
- R7: A select change made while a switch is in progress is taken only after that switch has completed. The intermediate source is therefore first reported in the status.
- R8: `clk_o` never shows a high or low phase shorter than the shortest half-period of the sources involved. At no time is more than one source enable active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-domain clock, on which the select is sampled and the status is produced |
| rst_n | input | 1 | Synchronous active-low reset; must be held for several cycles of every source clock |
| sel_i | input | SEL_W | Requested source index |
| src_clk_i | input | N_SRC | Source clocks, bit i being source i |
| clk_o | output | 1 | Selected, glitch-free output clock |
| status_o | output | N_SRC | One-hot source-in-use indication, zero while switching |

## Verification
The checker evaluates these properties on every register-clock cycle:
- the status is at most one-hot;
- at most one source enable is active;
- an accepted change forces the status to zero on the next cycle;
- invalid codes leave the status untouched;
- the target does not move while a switch is pending;
- reset yields 0x01.

Some behaviours only the bench scenarios can show, using clocks of unrelated periods:
- the absence of runt phases on the output, measured in real time;
- that the output period matches the chosen source;
- that a switch stalls while its target clock is stopped and resumes when the clock restarts;
- that a queued request completes only after the intermediate source has been reported.

// File: rtl/gfcs_pkg.sv
// Package: shared helpers for the glitch-free clock selector.
// Assumes nothing beyond plain elaboration-time arithmetic.
package gfcs_pkg;

    // Width of a select field able to index n sources (at least one bit).
    function automatic int unsigned sel_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gfcs_sync.sv
// Two-flop synchroniser for a vector of independent, slowly changing bits.
// Assumes each bit is quasi-static relative to clk_i (levels, not pulses).
module gfcs_sync #(
    parameter int unsigned        W   = 1,
    parameter logic [W-1:0]       RST = '0
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Purpose: move d_i into the clk_i domain through two flops.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            stage1 <= RST;
            stage2 <= RST;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/gfcs_leg.sv
// One source leg: sync the grant request and the "all other legs released"
// flag into this source's domain, then update the output enable on the
// falling edge so the gated clock is low whenever the enable moves.
// Assumes rst_n is held for at least three cycles of this source clock.
module gfcs_leg #(
    parameter bit EN_RST = 1'b0
) (
    input  logic src_clk_i,
    input  logic rst_n,
    input  logic grant_i,
    input  logic others_off_i,
    output logic en_o
);
    logic grant_s;
    logic others_off_s;

    gfcs_sync #(.W(2), .RST({EN_RST, 1'b1})) u_sync (
        .clk_i (src_clk_i),
        .rst_n (rst_n),
        .d_i   ({grant_i, others_off_i}),
        .q_o   ({grant_s, others_off_s})
    );

    // Purpose: enable only when granted and every other leg has let go.
    always_ff @(negedge src_clk_i) begin
        if (!rst_n) begin
            en_o <= EN_RST;
        end else begin
            en_o <= grant_s & others_off_s;
        end
    end
endmodule

// File: rtl/gfcs_ctrl.sv
// Register-domain controller: holds the granted source as a one-hot
// target, accepts a new valid select only while settled, and derives the
// status from the synchronised leg enables.
// Assumes sel_i is synchronous to reg_clk.
module gfcs_ctrl #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned SEL_W = 3
) (
    input  logic             reg_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_SRC-1:0] en_i,
    output logic [N_SRC-1:0] tgt_oh_o,
    output logic [N_SRC-1:0] status_o
);
    localparam logic [N_SRC-1:0] DEF_OH = N_SRC'(1);

    logic [N_SRC-1:0] en_s;
    logic [N_SRC-1:0] sel_oh;
    logic             settled;
    logic             take;

    gfcs_sync #(.W(N_SRC), .RST(DEF_OH)) u_en_sync (
        .clk_i (reg_clk),
        .rst_n (rst_n),
        .d_i   (en_i),
        .q_o   (en_s)
    );

    // Purpose: decode the select; out-of-range codes decode to nothing.
    always_comb begin
        sel_oh = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_i == SEL_W'(i)) sel_oh[i] = 1'b1;
        end
    end

    assign settled = (en_s == tgt_oh_o);
    assign take    = settled && (sel_oh != '0) && (sel_oh != tgt_oh_o);

    // Purpose: latch a new target only between switches.
    always_ff @(posedge reg_clk) begin
        if (!rst_n) begin
            tgt_oh_o <= DEF_OH;
        end else if (take) begin
            tgt_oh_o <= sel_oh;
        end
    end

    assign status_o = settled ? en_s : '0;
endmodule

// File: rtl/gf_clk_sel.sv
// Top: glitch-free N-way clock selector. Each source has a leg that gates
// its clock; the legs interlock through "others released" flags so that the
// outgoing enable drops before the incoming one rises.
// Assumes all source clocks run during reset, and that rst_n is held for
// several cycles of the slowest source.
module gf_clk_sel #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned SEL_W = gfcs_pkg::sel_width(N_SRC)
) (
    input  logic             reg_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_SRC-1:0] src_clk_i,
    output logic             clk_o,
    output logic [N_SRC-1:0] status_o
);
    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] tgt_oh;
    logic [N_SRC-1:0] others_off;

    gfcs_ctrl #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_ctrl (
        .reg_clk  (reg_clk),
        .rst_n    (rst_n),
        .sel_i    (sel_i),
        .en_i     (en),
        .tgt_oh_o (tgt_oh),
        .status_o (status_o)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_leg
        // Purpose: flag that every leg except this one is disabled.
        always_comb begin
            others_off[g] = 1'b1;
            for (int j = 0; j < N_SRC; j++) begin
                if (j != g && en[j]) others_off[g] = 1'b0;
            end
        end

        gfcs_leg #(.EN_RST(g == 0)) u_leg (
            .src_clk_i    (src_clk_i[g]),
            .rst_n        (rst_n),
            .grant_i      (tgt_oh[g]),
            .others_off_i (others_off[g]),
            .en_o         (en[g])
        );
    end

    // Purpose: behavioural AND-OR gating of the enabled source.
    assign clk_o = |(src_clk_i & en);
endmodule

// File: rtl/gf_clk_sel_chk.sv
// Checker: cycle-level properties of the selector in the reg_clk domain.
module gf_clk_sel_chk #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned SEL_W = 3
) (
    input logic             reg_clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel_i,
    input logic [N_SRC-1:0] status_o,
    input logic [N_SRC-1:0] tgt_oh,
    input logic [N_SRC-1:0] en
);
    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    a_r2_status_onehot0: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(status_o));

    a_r8_single_enable: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(en));

    a_r3_zero_after_take: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (status_o != '0 && sel_i < N_SRC && status_o != (ONE << sel_i))
        |=> (status_o == '0));

    a_r4_invalid_ignored: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (status_o != '0 && sel_i >= N_SRC) |=> $stable(status_o));

    a_r7_no_retarget_midswitch: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (status_o == '0) |=> $stable(tgt_oh));

    a_r5_reset_default: assert property (@(posedge reg_clk)
        (!rst_n) |=> (status_o == ONE));
endmodule

bind gf_clk_sel gf_clk_sel_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
    .reg_clk  (reg_clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .status_o (status_o),
    .tgt_oh   (tgt_oh),
    .en       (en)
);

// File: tb/gf_clk_sel_tb.sv
`timescale 1ns/1ps
module gf_clk_sel_tb;
    localparam int N = 5;
    localparam int SW = 3;
    localparam real MIN_HALF = 3.6;

    logic          reg_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic [SW-1:0] sel     = '0;
    logic [N-1:0]  src;
    logic [N-1:0]  run     = '1;
    logic          clk_o;
    logic [N-1:0]  status;

    int tests = 0;
    int fails = 0;
    int glitches = 0;
    bit finished = 0;

    function automatic real per(input int i);
        case (i)
            0: return 10.0;
            1: return 13.4;
            2: return 7.2;
            3: return 17.0;
            default: return 22.6;
        endcase
    endfunction

    function automatic logic [N-1:0] exp_status(input int idx);
        return N'(1) << idx;
    endfunction

    always #4 reg_clk = ~reg_clk;

    for (genvar g = 0; g < N; g++) begin : g_src
        logic c = 1'b0;
        always begin
            #(per(g) / 2.0);
            c = run[g] ? ~c : 1'b0;
        end
        assign src[g] = c;
    end

    gf_clk_sel #(.N_SRC(N)) u_dut (
        .reg_clk   (reg_clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .src_clk_i (src),
        .clk_o     (clk_o),
        .status_o  (status)
    );

    // Runt-phase monitor (R8)
    real last_t = 0.0;
    bit  have_last = 0;
    always @(clk_o) begin
        if (rst_n && !$isunknown(clk_o)) begin
            if (have_last && ($realtime - last_t) < MIN_HALF - 0.01) glitches++;
            last_t = $realtime;
            have_last = 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_period(input string req, input int idx);
        real t0, t1;
        @(posedge clk_o); t0 = $realtime;
        @(posedge clk_o); t1 = $realtime;
        tests++;
        if ((t1 - t0) > per(idx) + 0.02 || (t1 - t0) < per(idx) - 0.02) begin
            fails++;
            $display("FAIL %s: actual period %0f expected %0f", req, t1 - t0, per(idx));
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge reg_clk);
    endtask

    task automatic wait_nonzero(output logic [N-1:0] v);
        v = '0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge reg_clk);
            if (status != '0) begin
                v = status;
                break;
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        int cur;
        int s;
        s = $urandom(32'd1234);
        cyc(25);
        chk("R5 reset status", 32'(status), 32'h01);
        rst_n = 1'b1;
        cyc(3);
        chk("R5 default after release", 32'(status), 32'h01);
        chk_period("R1 source 0 period", 0);

        // directed switch 0 -> 3
        @(negedge reg_clk); sel = 3'd3;
        @(negedge reg_clk);
        chk("R3 zero after accept", 32'(status), 32'h0);
        wait_nonzero(v);
        chk("R2 source 3 code", 32'(v), 32'h08);
        chk_period("R1 source 3 period", 3);
        cur = 3;

        // invalid codes ignored
        for (int c = 5; c < 8; c++) begin
            @(negedge reg_clk); sel = SW'(c);
            cyc(40);
            chk("R4 invalid code ignored", 32'(status), 32'h08);
        end
        chk_period("R4 clock unchanged", 3);

        // stall toward a stopped clock, then queue another request
        run[1] = 1'b0;
        @(negedge reg_clk); sel = 3'd1;
        cyc(300);
        chk("R6 stalled status", 32'(status), 32'h0);
        chk("R6 output held low", 32'(clk_o), 32'h0);
        sel = 3'd2;
        cyc(100);
        chk("R7 still stalled", 32'(status), 32'h0);
        run[1] = 1'b1;
        wait_nonzero(v);
        chk("R7 intermediate source reported", 32'(v), 32'h02);
        @(negedge reg_clk);
        chk("R3 zero on queued accept", 32'(status), 32'h0);
        wait_nonzero(v);
        chk("R7 queued source reached", 32'(v), 32'h04);
        chk_period("R1 source 2 period", 2);
        cur = 2;

        // constrained random selects
        for (int it = 0; it < 30; it++) begin
            s = int'($urandom % 8);
            @(negedge reg_clk); sel = SW'(s);
            if (s < N && s != cur) begin
                @(negedge reg_clk);
                chk("R3 zero after random accept", 32'(status), 32'h0);
                wait_nonzero(v);
                chk("R2 random source code", 32'(v), 32'(exp_status(s)));
                chk_period("R1 random source period", s);
                cur = s;
            end else begin
                cyc(20);
                chk("R4 no change", 32'(status), 32'(exp_status(cur)));
            end
        end

        chk("R8 no runt phases", glitches, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule